// File: doc/BRIEF.md
# Receive descriptor ring engine

The engine takes one incoming Ethernet frame at a time and stores it in system memory. Memory buffers are described by up to four circular lists of descriptors (rings) that software prepares. For each frame it searches the rings in fixed priority order, lowest index first, for a descriptor that software has handed over and whose buffer is large enough. It copies the frame into that buffer, leaving a programmable gap of header bytes at the front. It then writes the descriptor back with ownership returned to software and the stored length filled in, and advances the ring's current pointer.

A successful receive sets a sticky cause bit, and an interrupt line follows cause AND mask. A frame for which no ring has a usable descriptor is dropped, and a counter records the drop. The frame source shows a length and then serves bytes by index. Memory is reached through a single word-wide master with a request/ready handshake and byte enables. Software programs the engine through a plain register write port and a combinational read port.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, irq, frm_done and mem_req are 0, and every register offset from 0x00 to 0x2C reads 0.
- R2: A descriptor is four little-endian 32-bit words at its address +0, +4, +8 and +12. They hold, in order: the status word, with ownership in bit 31; a word whose bits 15:0 are the received byte count and bits 31:16 the buffer size; the buffer address; and the next-descriptor address. The engine reads all four words before deciding on a descriptor.
- R3: Writing ring i's head register (offset 0x10+4i) loads the head pointer and the current pointer (offset 0x20+4i) with the same value, and both read back.
- R4: Rings are examined from 0 to 3. A ring whose current pointer is 0 is skipped. The first usable descriptor found takes the frame, and no other descriptor is touched.
- R5: A descriptor is usable only if status bit 31 is 1 and buffer size is at least the frame length; a length equal to the buffer size is usable. When a descriptor is unusable, the engine follows its next pointer. It leaves the ring when that next pointer equals the ring's head pointer.
- R6: Frame byte k goes to byte address buffer + gap + k, where gap is the register at offset 0x08 bits 7:0. It is written as a single-byte access on lane (address mod 4). No byte outside that span is written, so a frame of length L costs L byte writes plus 4 descriptor writes.
- R7: In the write-back, bit 31 of the status word is cleared and its other bits are kept. The byte count becomes length + gap, and buffer size, buffer address and next address are unchanged. The ring's current pointer becomes the next address.
- R8: A successful receive sets cause bit 0 (offset 0x00), and writing 1 to that bit clears it. irq is 1 exactly when cause bit 0 and mask bit 0 (offset 0x04) are both 1.
- R9: When no ring holds a usable descriptor, the frame is dropped. frm_done rises with frm_drop = 1, the drop counter (offset 0x0C) increments, no memory write is made and the cause bit does not change.
- R10: A memory request that is not accepted stays asserted, with the same address and direction, until mem_ready is 1.
- R11: Every accepted frame completes with frm_done high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Frame pending; held until frm_done |
| frm_len | input | 16 | Frame length in bytes, held with frm_valid |
| frm_byte_idx | output | 16 | Index of the frame byte wanted |
| frm_byte | input | 8 | Frame byte at frm_byte_idx |
| frm_done | output | 1 | One-cycle completion pulse |
| frm_drop | output | 1 | Qualifies frm_done: frame was dropped |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Masked receive interrupt |

## Verification
On every cycle, the assertions check several properties. A stalled memory request holds its address and direction until accepted. The completion pulse is a single cycle. The drop counter moves only on a dropped completion, and the cause bit rises only on a successful one. The bench scenarios are the only way to show the rest. These are the search order across rings and the skipping of a zero ring. They also cover following next pointers and stopping at the head, the size boundary, and the exact byte image with its header gap under every lane alignment. The remaining items are the written-back descriptor contents, and interrupt masking and clearing.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int RINGS   = 4,
  parameter int LW      = 16,
  parameter int GW      = 8,
  parameter int DW      = 16,
  parameter int OWN_BIT = 31
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid,
  input  logic [LW-1:0] frm_len,
  output logic [LW-1:0] frm_byte_idx,
  input  logic [7:0]    frm_byte,
  output logic          frm_done,
  output logic          frm_drop,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  localparam int RW = (RINGS > 1) ? $clog2(RINGS) : 1;
  localparam logic [7:0] HEAD_BASE = 8'h10;
  localparam logic [7:0] CUR_BASE  = 8'(16 + 4 * RINGS);

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_RD, S_CHK, S_WRB, S_WB, S_DONE} st_t;

  st_t           st;
  logic [RW-1:0] ring;
  logic [1:0]    widx;
  logic [31:0]   dptr, d_cs, d_buf, d_next;
  logic [15:0]   d_bsz;
  logic [LW-1:0] len_r, bcnt;
  logic [GW-1:0] gap_r;
  logic [DW-1:0] drops;
  logic          cause, mask, drop_r;
  logic [31:0]   hd_q  [RINGS];
  logic [31:0]   cur_q [RINGS];

  wire        last_ring = (ring == RW'(RINGS - 1));
  wire        usable    = d_cs[OWN_BIT] && (d_bsz >= 16'(len_r));
  wire [15:0] cnt_field = 16'(len_r) + 16'(gap_r);
  wire [31:0] byte_addr = d_buf + 32'(gap_r) + 32'(bcnt);
  wire [31:0] desc_addr = dptr + {28'd0, widx, 2'b00};

  assign mem_req      = (st == S_RD) || (st == S_WRB) || (st == S_WB);
  assign mem_we       = (st == S_WRB) || (st == S_WB);
  assign mem_addr     = (st == S_WRB) ? {byte_addr[31:2], 2'b00} : desc_addr;
  assign mem_be       = (st == S_WRB) ? (4'b0001 << byte_addr[1:0]) : 4'hF;
  assign frm_byte_idx = bcnt;
  assign frm_done     = (st == S_DONE);
  assign frm_drop     = drop_r;
  assign irq          = cause & mask;

  always_comb begin
    mem_wdata = '0;
    if (st == S_WRB) mem_wdata = {4{frm_byte}};
    else if (st == S_WB) begin
      case (widx)
        2'd0: mem_wdata = d_cs & ~(32'd1 << OWN_BIT);
        2'd1: mem_wdata = {d_bsz, cnt_field};
        2'd2: mem_wdata = d_buf;
        2'd3: mem_wdata = d_next;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      8'h00:   reg_rdata = {31'd0, cause};
      8'h04:   reg_rdata = {31'd0, mask};
      8'h08:   reg_rdata = 32'(gap_r);
      8'h0C:   reg_rdata = 32'(drops);
      default: reg_rdata = '0;
    endcase
    for (int i = 0; i < RINGS; i++) begin
      if (reg_addr == HEAD_BASE + 8'(4 * i)) reg_rdata = hd_q[i];
      if (reg_addr == CUR_BASE  + 8'(4 * i)) reg_rdata = cur_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ring   <= '0;
      widx   <= '0;
      dptr   <= '0;
      d_cs   <= '0;
      d_bsz  <= '0;
      d_buf  <= '0;
      d_next <= '0;
      len_r  <= '0;
      bcnt   <= '0;
      gap_r  <= '0;
      drops  <= '0;
      cause  <= 1'b0;
      mask   <= 1'b0;
      drop_r <= 1'b0;
      for (int i = 0; i < RINGS; i++) begin
        hd_q[i]  <= '0;
        cur_q[i] <= '0;
      end
    end else begin
      if (reg_we && reg_addr == 8'h00 && reg_wdata[0]) cause <= 1'b0;
      if (reg_we && reg_addr == 8'h04) mask  <= reg_wdata[0];
      if (reg_we && reg_addr == 8'h08) gap_r <= reg_wdata[GW-1:0];

      case (st)
        S_IDLE: if (frm_valid) begin
          len_r  <= frm_len;
          ring   <= '0;
          drop_r <= 1'b0;
          st     <= S_SEL;
        end
        S_SEL: begin
          if (cur_q[ring] == 32'd0) begin
            if (last_ring) begin
              drop_r <= 1'b1;
              drops  <= drops + DW'(1);
              st     <= S_DONE;
            end else begin
              ring <= ring + RW'(1);
              st   <= S_SEL;
            end
          end else begin
            dptr <= cur_q[ring];
            widx <= '0;
            st   <= S_RD;
          end
        end
        S_RD: if (mem_ready) begin
          case (widx)
            2'd0: d_cs   <= mem_rdata;
            2'd1: d_bsz  <= mem_rdata[31:16];
            2'd2: d_buf  <= mem_rdata;
            2'd3: d_next <= mem_rdata;
          endcase
          widx <= widx + 2'd1;
          if (widx == 2'd3) st <= S_CHK;
        end
        S_CHK: begin
          if (usable) begin
            bcnt <= '0;
            widx <= '0;
            st   <= (len_r == '0) ? S_WB : S_WRB;
          end else if (d_next == hd_q[ring]) begin
            if (last_ring) begin
              drop_r <= 1'b1;
              drops  <= drops + DW'(1);
              st     <= S_DONE;
            end else begin
              ring <= ring + RW'(1);
              st   <= S_SEL;
            end
          end else begin
            dptr <= d_next;
            widx <= '0;
            st   <= S_RD;
          end
        end
        S_WRB: if (mem_ready) begin
          if (bcnt == len_r - LW'(1)) begin
            widx <= '0;
            st   <= S_WB;
          end else begin
            bcnt <= bcnt + LW'(1);
          end
        end
        S_WB: if (mem_ready) begin
          widx <= widx + 2'd1;
          if (widx == 2'd3) begin
            cur_q[ring] <= d_next;
            cause       <= 1'b1;
            st          <= S_DONE;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

      for (int i = 0; i < RINGS; i++) begin
        if (reg_we && reg_addr == HEAD_BASE + 8'(4 * i)) begin
          hd_q[i]  <= reg_wdata;
          cur_q[i] <= reg_wdata;
        end
      end
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done);

  // R9
  drop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drops) |-> frm_done && frm_drop);

  // R8
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause) |-> frm_done && !frm_drop);

  // R9
  drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && frm_drop |-> $stable(cause) || !cause);
endmodule

// File: tb/rx_ring_dma_tb.sv
module rx_ring_dma_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [15:0] frm_len = '0;
  logic [15:0] frm_byte_idx;
  logic [7:0]  frm_byte;
  logic        frm_done, frm_drop;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  logic [31:0] mem [1024];
  logic [7:0]  fbuf [256];
  logic [7:0]  lfsr = 8'h5A;
  int          wr_count = 0;
  int          nvec = 0;
  int          nbad = 0;
  bit          finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  rx_ring_dma u_dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_byte_idx(frm_byte_idx), .frm_byte(frm_byte), .frm_done(frm_done),
    .frm_drop(frm_drop), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  assign frm_byte  = fbuf[frm_byte_idx[7:0]];
  assign mem_rdata = mem[mem_addr[11:2]];
  assign mem_ready = lfsr[0] | lfsr[2];

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      wr_count <= wr_count + 1;
    end
  end

  function automatic logic [7:0] pat(int s, int k);
    return 8'((k * 13 + s * 7 + 1) & 255);
  endfunction

  function automatic logic [7:0] getb(int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic putb(int a, logic [7:0] v);
    mem[a >> 2][8*(a % 4) +: 8] = v;
  endtask

  task automatic put_desc(int a, logic [31:0] cs, logic [15:0] cnt, logic [15:0] bsz,
                          logic [31:0] bufa, logic [31:0] nxt);
    mem[(a >> 2)]     = cs;
    mem[(a >> 2) + 1] = {bsz, cnt};
    mem[(a >> 2) + 2] = bufa;
    mem[(a >> 2) + 3] = nxt;
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic send(int len, int seed, output logic dropped);
    int n;
    for (int k = 0; k < 256; k++) fbuf[k] = pat(seed, k);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 16'(len);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!frm_done && n < 20000);
    chk("R11 frame completes", {31'd0, frm_done}, 32'd1);
    dropped = frm_drop;
    frm_valid = 1'b0;
    @(negedge clk);
    chk("R11 done is one cycle", {31'd0, frm_done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic dr;
    int bad, seed, wb;
    logic [7:0] e;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int k = 0; k < 256; k++) fbuf[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 frm_done", {31'd0, frm_done}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    for (int a = 0; a < 12; a++) begin
      reg_rd(8'(4 * a), v);
      chk("R1 register", v, 0);
    end

    // R6 R7 R2: sweep of gap and length on a one-entry ring
    for (int g = 0; g < 4; g++) begin
      for (int L = 0; L < 9; L++) begin
        put_desc(32'h100, 32'h8000_0055, 16'd0, 16'd64, 32'h400, 32'h100);
        for (int a = 0; a < 64; a++) putb(32'h400 + a, 8'hEE);
        reg_wr(8'h08, g);
        reg_wr(8'h10, 32'h100);
        seed = g * 9 + L;
        wb = wr_count;
        send(L, seed, dr);
        chk("R9 success not dropped", {31'd0, dr}, 0);
        bad = 0;
        for (int a = 0; a < 64; a++) begin
          e = (a >= g && a < g + L) ? pat(seed, a - g) : 8'hEE;
          if (getb(32'h400 + a) !== e) bad++;
        end
        chk("R6 buffer image with gap", bad, 0);
        chk("R6 write count", wr_count - wb, L + 4);
        chk("R7 status own cleared", mem[32'h100 >> 2], 32'h0000_0055);
        chk("R7 count and size word", mem[(32'h100 >> 2) + 1], {16'd64, 16'(L + g)});
        chk("R2 buffer word kept", mem[(32'h100 >> 2) + 2], 32'h400);
        chk("R2 next word kept", mem[(32'h100 >> 2) + 3], 32'h100);
        reg_rd(8'h20, v);
        chk("R7 current pointer advanced", v, 32'h100);
      end
    end

    // R8 masking and clearing
    chk("R8 irq masked", {31'd0, irq}, 0);
    reg_rd(8'h00, v);
    chk("R8 cause set", v, 1);
    reg_wr(8'h04, 1);
    chk("R8 irq when unmasked", {31'd0, irq}, 1);
    reg_wr(8'h00, 1);
    chk("R8 irq after clear", {31'd0, irq}, 0);
    reg_rd(8'h00, v);
    chk("R8 cause cleared", v, 0);

    // R5 skipping unusable descriptors
    put_desc(32'h200, 32'h0000_0011, 16'd0, 16'd64, 32'h600, 32'h210);
    put_desc(32'h210, 32'h8000_0000, 16'd0, 16'd4,  32'h680, 32'h220);
    put_desc(32'h220, 32'h8000_0000, 16'd0, 16'd64, 32'h700, 32'h200);
    reg_wr(8'h08, 0);
    reg_wr(8'h10, 32'h200);
    send(5, 40, dr);
    chk("R5 third descriptor taken", mem[32'h220 >> 2], 0);
    chk("R5 third count", mem[(32'h220 >> 2) + 1], {16'd64, 16'd5});
    chk("R5 unowned untouched", mem[32'h200 >> 2], 32'h11);
    chk("R5 small buffer untouched", mem[(32'h210 >> 2) + 1], {16'd4, 16'd0});
    chk("R6 first byte", getb(32'h700), pat(40, 0));
    chk("R6 last byte", getb(32'h704), pat(40, 4));
    reg_rd(8'h20, v);
    chk("R7 current wraps to head", v, 32'h200);
    chk("R8 cause after skip", {31'd0, irq}, 1);

    // R5 equal size boundary
    put_desc(32'h210, 32'h8000_0000, 16'd0, 16'd5, 32'h680, 32'h220);
    reg_wr(8'h10, 32'h200);
    send(5, 41, dr);
    chk("R5 size equal to length usable", mem[32'h210 >> 2], 0);
    chk("R5 size equal count", mem[(32'h210 >> 2) + 1], {16'd5, 16'd5});
    reg_rd(8'h20, v);
    chk("R7 current after boundary", v, 32'h220);

    // R4 priority across rings
    reg_wr(8'h00, 1);
    reg_wr(8'h10, 0);
    put_desc(32'h300, 32'h8000_0000, 16'd0, 16'd64, 32'h800, 32'h300);
    put_desc(32'h340, 32'h8000_0000, 16'd0, 16'd64, 32'h900, 32'h340);
    reg_wr(8'h14, 32'h300);
    reg_wr(8'h18, 32'h340);
    reg_wr(8'h08, 1);
    send(4, 50, dr);
    chk("R4 ring1 before ring2", mem[32'h300 >> 2], 0);
    chk("R4 ring2 untouched", mem[32'h340 >> 2], 32'h8000_0000);
    chk("R6 byte at gap", getb(32'h801), pat(50, 0));
    send(4, 51, dr);
    chk("R4 falls to ring2", mem[32'h340 >> 2], 0);
    chk("R4 ring2 count", mem[(32'h340 >> 2) + 1], {16'd64, 16'd5});
    chk("R6 ring2 byte", getb(32'h904), pat(51, 3));

    // R9 drop
    reg_wr(8'h00, 1);
    wb = wr_count;
    send(3, 60, dr);
    chk("R9 dropped flag", {31'd0, dr}, 1);
    chk("R9 no memory writes", wr_count - wb, 0);
    reg_rd(8'h0C, v);
    chk("R9 drop counter", v, 1);
    reg_rd(8'h00, v);
    chk("R9 cause unchanged", v, 0);
    chk("R9 irq low", {31'd0, irq}, 0);

    // R3 head write loads both pointers
    reg_wr(8'h1C, 32'h3F0);
    reg_rd(8'h1C, v);
    chk("R3 head readback", v, 32'h3F0);
    reg_rd(8'h2C, v);
    chk("R3 current loaded", v, 32'h3F0);
    reg_rd(8'h24, v);
    chk("R3 other ring current", v, 32'h300);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule